// File: doc/BRIEF.md
# Packed-Nibble Tag Range Checker

This block decides whether a memory access of 1 to 256 bytes carries the right 4-bit logical tag for every 16-byte granule it touches. Allocation tags sit in a tag memory with two tags per byte. The checker is given the access start address, the access length minus one and the pointer's logical tag. It works out how many granules the range covers and fetches the tag bytes in ascending order, one byte per cycle. It compares the granule tags in address order and stops at the first mismatch.

The result comes back as a one-cycle `done` pulse. With it come `pass` and, when the check fails, the address of the first faulting byte. A new check may start only while the block is idle. The tag memory is reached through a plain synchronous read port: a request in one cycle returns its data in the next.

Top module: `tag_range_checker`

## Requirements
- R1: Tag byte index is address >> 5. Address bit 4 selects the nibble: bits [3:0] of a tag byte hold the tag of the lower-addressed granule and bits [7:4] hold the tag of the higher-addressed granule.
- R2: The number of granules checked is ((address + size_m1) >> 4) − (address >> 4) + 1. This ranges from 1 to 17.
- R3: When address bit 4 is set, comparison begins on the high nibble of the first byte. It then continues with the low nibble of the following byte.
- R4: Comparison stops at the first mismatching granule and no further tag byte is requested. The check passes only when every granule tag equals the pointer tag.
- R5: On a mismatch in the first granule, `fault_addr` is the access address. On a mismatch in a later granule, it is the 16-byte-aligned start address plus 16 × (number of granules that matched).
- R6: `done` is high for exactly one cycle, in the cycle after the data of the last compared tag byte arrives. With a start accepted at edge k and B bytes compared, `done` is high after edge k+1+B and `busy` is low in that cycle.
- R7: `start` is ignored while `busy` is high. Every rise of `busy` follows an accepted `start`.
- R8: When a check passes, `fault_addr` reads zero together with `done`.
- R9: Tag bytes are requested at consecutive ascending byte indices, and a request is made only while `busy` is high.
- R10: After reset, `busy`, `done`, `pass` and `tm_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check (accepted only when idle) |
| acc_addr | input | ADDR_W | Access start byte address |
| acc_size_m1 | input | SIZE_W | Access length in bytes minus one |
| ptr_tag | input | TAG_W | Logical tag of the pointer |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | All granule tags matched (valid with done) |
| fault_addr | output | ADDR_W | First faulting address, zero on pass |
| tm_rd_en | output | 1 | Tag memory read request |
| tm_rd_addr | output | ADDR_W-5 | Tag byte index |
| tm_rd_data | input | 2*TAG_W | Tag byte, valid the cycle after the request |

## Verification
A result is due at a fixed edge: one fetch cycle after the start edge, plus one cycle for each tag byte compared up to the stopping byte. A pass stops at the last byte of the range, and a fail stops at the byte that holds the first bad granule. The driver computes that byte count from its own tag model and pushes the due cycle with the expected verdict. The monitor compares the cycle in which `done` appears to that value, and it compares the number of read requests it counted to the same byte count. This catches an early finish, a late finish and reads that continue past a mismatch.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;

    typedef enum logic [1:0] {
        TC_IDLE  = 2'd0,
        TC_FETCH = 2'd1,
        TC_CMP   = 2'd2
    } tc_state_e;

endpackage

// File: rtl/tagchk_span.sv
// Derives the granule count, aligned granule base, first tag byte index and
// starting nibble from the access address and length.
module tagchk_span #(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 8,
    parameter int GRAN_LOG2 = 4,
    parameter int CNT_W     = 5,
    localparam int BIDX_W   = ADDR_W - GRAN_LOG2 - 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size_m1,
    output logic [CNT_W-1:0]  gran_cnt,
    output logic [ADDR_W-1:0] gran_base,
    output logic [BIDX_W-1:0] byte_idx,
    output logic              start_hi
);
    logic [ADDR_W-1:0] last_addr;
    logic [ADDR_W-1:0] gran_diff;

    always_comb begin
        last_addr = addr + ADDR_W'(size_m1);
        gran_diff = (last_addr >> GRAN_LOG2) - (addr >> GRAN_LOG2);
        gran_cnt  = gran_diff[CNT_W-1:0] + CNT_W'(1);
        gran_base = {addr[ADDR_W-1:GRAN_LOG2], {GRAN_LOG2{1'b0}}};
        byte_idx  = addr[ADDR_W-1:GRAN_LOG2+1];
        start_hi  = addr[GRAN_LOG2];
    end
endmodule

// File: rtl/tagchk_nib_cmp.sv
// Compares both nibbles of one tag byte against the replicated pointer tag.
module tagchk_nib_cmp #(
    parameter int TAG_W = 4,
    localparam int LANES = 2
) (
    input  logic [LANES*TAG_W-1:0] tag_byte,
    input  logic [TAG_W-1:0]       ptr_tag,
    output logic [LANES-1:0]       mismatch
);
    logic [LANES*TAG_W-1:0] diff;

    assign diff = tag_byte ^ {LANES{ptr_tag}};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mismatch[g] = |diff[g*TAG_W +: TAG_W];
    end
endmodule

// File: rtl/tagchk_fault.sv
// Forms the fault address from the number of granules matched before the
// failing one.
module tagchk_fault #(
    parameter int ADDR_W    = 32,
    parameter int GRAN_LOG2 = 4,
    parameter int CNT_W     = 5
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [ADDR_W-1:0] gran_base,
    input  logic [CNT_W-1:0]  n_ok,
    output logic [ADDR_W-1:0] fault_addr
);
    always_comb begin
        if (n_ok == '0) begin
            fault_addr = acc_addr;
        end else begin
            fault_addr = gran_base + (ADDR_W'(n_ok) << GRAN_LOG2);
        end
    end
endmodule

// File: rtl/tag_range_checker.sv
module tag_range_checker
    import tagchk_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 8,
    parameter int TAG_W     = 4,
    parameter int GRAN_LOG2 = 4,
    localparam int BIDX_W   = ADDR_W - GRAN_LOG2 - 1,
    localparam int MAX_GRAN = ((1 << SIZE_W) - 1) / (1 << GRAN_LOG2) + 2,
    localparam int CNT_W    = $clog2(MAX_GRAN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [SIZE_W-1:0]   acc_size_m1,
    input  logic [TAG_W-1:0]    ptr_tag,
    output logic                busy,
    output logic                done,
    output logic                pass,
    output logic [ADDR_W-1:0]   fault_addr,
    output logic                tm_rd_en,
    output logic [BIDX_W-1:0]   tm_rd_addr,
    input  logic [2*TAG_W-1:0]  tm_rd_data
);

    typedef struct packed {
        tc_state_e          st;
        logic [ADDR_W-1:0]  addr;
        logic [ADDR_W-1:0]  gbase;
        logic [TAG_W-1:0]   tag;
        logic [CNT_W-1:0]   total;
        logic [CNT_W-1:0]   matched;
        logic               odd;
        logic [BIDX_W-1:0]  bidx;
        logic               done;
        logic               pass;
        logic [ADDR_W-1:0]  fault;
    } tc_regs_t;

    tc_regs_t r_q, r_d;

    logic [CNT_W-1:0]  span_cnt;
    logic [ADDR_W-1:0] span_base;
    logic [BIDX_W-1:0] span_bidx;
    logic              span_hi;
    logic [1:0]        nib_bad;
    logic [CNT_W-1:0]  fail_n;
    logic [ADDR_W-1:0] fail_addr;
    logic              rd_en_d;

    tagchk_span #(
        .ADDR_W    (ADDR_W),
        .SIZE_W    (SIZE_W),
        .GRAN_LOG2 (GRAN_LOG2),
        .CNT_W     (CNT_W)
    ) u_span (
        .addr      (acc_addr),
        .size_m1   (acc_size_m1),
        .gran_cnt  (span_cnt),
        .gran_base (span_base),
        .byte_idx  (span_bidx),
        .start_hi  (span_hi)
    );

    tagchk_nib_cmp #(
        .TAG_W (TAG_W)
    ) u_cmp (
        .tag_byte (tm_rd_data),
        .ptr_tag  (r_q.tag),
        .mismatch (nib_bad)
    );

    tagchk_fault #(
        .ADDR_W    (ADDR_W),
        .GRAN_LOG2 (GRAN_LOG2),
        .CNT_W     (CNT_W)
    ) u_fault (
        .acc_addr   (r_q.addr),
        .gran_base  (r_q.gbase),
        .n_ok       (fail_n),
        .fault_addr (fail_addr)
    );

    always_comb begin
        logic [CNT_W-1:0] remain;
        logic             finish;
        logic             ok;
        logic [CNT_W-1:0] adv;

        r_d      = r_q;
        r_d.done = 1'b0;
        rd_en_d  = 1'b0;
        remain   = r_q.total - r_q.matched;
        finish   = 1'b0;
        ok       = 1'b0;
        adv      = '0;
        fail_n   = r_q.matched;

        unique case (r_q.st)
            TC_IDLE: begin
                if (start) begin
                    r_d.st      = TC_FETCH;
                    r_d.addr    = acc_addr;
                    r_d.gbase   = span_base;
                    r_d.tag     = ptr_tag;
                    r_d.total   = span_cnt;
                    r_d.matched = '0;
                    r_d.odd     = span_hi;
                    r_d.bidx    = span_bidx;
                end
            end
            TC_FETCH: begin
                rd_en_d  = 1'b1;
                r_d.bidx = r_q.bidx + BIDX_W'(1);
                r_d.st   = TC_CMP;
            end
            TC_CMP: begin
                if (!r_q.odd) begin
                    if (nib_bad[0]) begin
                        finish = 1'b1;
                    end else if (remain == CNT_W'(1)) begin
                        finish = 1'b1;
                        ok     = 1'b1;
                    end else if (nib_bad[1]) begin
                        finish = 1'b1;
                        fail_n = r_q.matched + CNT_W'(1);
                    end else if (remain == CNT_W'(2)) begin
                        finish = 1'b1;
                        ok     = 1'b1;
                    end else begin
                        adv = CNT_W'(2);
                    end
                end else begin
                    if (nib_bad[1]) begin
                        finish = 1'b1;
                    end else if (remain == CNT_W'(1)) begin
                        finish = 1'b1;
                        ok     = 1'b1;
                    end else begin
                        adv = CNT_W'(1);
                    end
                end

                if (finish) begin
                    r_d.st    = TC_IDLE;
                    r_d.done  = 1'b1;
                    r_d.pass  = ok;
                    r_d.fault = ok ? '0 : fail_addr;
                end else begin
                    r_d.matched = r_q.matched + adv;
                    r_d.odd     = 1'b0;
                    r_d.bidx    = r_q.bidx + BIDX_W'(1);
                    rd_en_d     = 1'b1;
                end
            end
            default: r_d.st = TC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != TC_IDLE);
    assign done       = r_q.done;
    assign pass       = r_q.pass;
    assign fault_addr = r_q.fault;
    assign tm_rd_en   = rd_en_d;
    assign tm_rd_addr = r_q.bidx;

endmodule

// File: rtl/tagchk_props.sv
module tagchk_props #(
    parameter int ADDR_W = 32,
    parameter int BIDX_W = 27
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic [ADDR_W-1:0] fault_addr,
    input logic              tm_rd_en,
    input logic [BIDX_W-1:0] tm_rd_addr
);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    pass_fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (fault_addr == '0));

    // R9
    rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tm_rd_en |-> busy);

    // R9
    rd_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_rd_en && $past(tm_rd_en)) |-> (tm_rd_addr == $past(tm_rd_addr) + 1'b1));

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind tag_range_checker tagchk_props #(
    .ADDR_W (ADDR_W),
    .BIDX_W (BIDX_W)
) u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .fault_addr (fault_addr),
    .tm_rd_en   (tm_rd_en),
    .tm_rd_addr (tm_rd_addr)
);

// File: tb/test_tag_range_checker.sv
`timescale 1ns/1ps
module test_tag_range_checker;

    localparam int AW = 32;
    localparam int BW = AW - 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [7:0]    acc_size_m1 = '0;
    logic [3:0]    ptr_tag = '0;
    logic          busy, done, pass;
    logic [AW-1:0] fault_addr;
    logic          tm_rd_en;
    logic [BW-1:0] tm_rd_addr;
    logic [7:0]    tm_rd_data = '0;

    logic [7:0] tmem [64];

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rd_cnt = 0;
    bit finished = 0;

    typedef struct {
        bit          ok;
        logic [31:0] fault;
        int          due;
        int          nrd;
        string       req;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tm_rd_en) tm_rd_data <= tmem[tm_rd_addr[5:0]];
    end

    tag_range_checker i_tag_range_checker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .acc_addr    (acc_addr),
        .acc_size_m1 (acc_size_m1),
        .ptr_tag     (ptr_tag),
        .busy        (busy),
        .done        (done),
        .pass        (pass),
        .fault_addr  (fault_addr),
        .tm_rd_en    (tm_rd_en),
        .tm_rd_addr  (tm_rd_addr),
        .tm_rd_data  (tm_rd_data)
    );

    task automatic chk(input bit cond, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // Reference model built from R1, R2, R3, R4, R5.
    task automatic model(input logic [31:0] a, input logic [7:0] sm1, input logic [3:0] t,
                         output bit ok, output logic [31:0] f, output int nb);
        logic [31:0] last, g0, ga;
        logic [3:0]  nib;
        int          cnt;
        last = a + {24'd0, sm1};
        cnt  = int'((last >> 4) - (a >> 4)) + 1;
        g0   = a & ~32'hF;
        ok   = 1;
        f    = '0;
        nb   = int'((last >> 5) - (a >> 5)) + 1;
        for (int i = 0; i < cnt; i++) begin
            ga  = g0 + 32'(16 * i);
            nib = ga[4] ? tmem[ga[10:5]][7:4] : tmem[ga[10:5]][3:0];
            if (nib != t) begin
                ok = 0;
                f  = (i == 0) ? a : ga;
                nb = int'((ga >> 5) - (a >> 5)) + 1;
                break;
            end
        end
    endtask

    // Driver: starts one check and pushes its expected outcome.
    task automatic run(input logic [31:0] a, input logic [7:0] sm1, input logic [3:0] t,
                       input string req, input bit dup);
        exp_t e;
        int   nb;
        @(negedge clk);
        model(a, sm1, t, e.ok, e.fault, nb);
        e.nrd = nb;
        e.due = cyc + 2 + nb;
        e.req = req;
        q.push_back(e);
        acc_addr    = a;
        acc_size_m1 = sm1;
        ptr_tag     = t;
        rd_cnt      = 0;
        start       = 1'b1;
        @(negedge clk);
        if (dup) begin
            // R7: second start during busy must be ignored
            chk(busy == 1'b1, "R7 busy", 32'(busy), 32'd1);
            acc_addr    = 32'h0000_0000;
            acc_size_m1 = 8'd0;
            ptr_tag     = 4'hE;
            @(negedge clk);
        end
        start = 1'b0;
        wait (q.size() == 0);
    endtask

    always @(negedge clk) begin
        if (tm_rd_en) rd_cnt++;
    end

    // Monitor: pops and compares each result as done appears.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                chk(1'b0, "R7 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(pass == e.ok, {e.req, " pass"}, 32'(pass), 32'(e.ok));
                chk(fault_addr == e.fault, {e.req, " fault_addr R5 R8"}, fault_addr, e.fault);
                chk(cyc == e.due, {e.req, " done cycle R6"}, 32'(cyc), 32'(e.due));
                chk(rd_cnt == e.nrd, {e.req, " read count R4"}, 32'(rd_cnt), 32'(e.nrd));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) tmem[i] = 8'h33;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(busy == 1'b0, "R10 busy", 32'(busy), 32'd0);
        chk(done == 1'b0, "R10 done", 32'(done), 32'd0);
        chk(pass == 1'b0, "R10 pass", 32'(pass), 32'd0);
        chk(tm_rd_en == 1'b0, "R10 rd_en", 32'(tm_rd_en), 32'd0);
        rst_n = 1'b1;

        // R2 one aligned granule
        run(32'h100, 8'd15, 4'h3, "R2 single granule", 0);
        // R3 start on high nibble, single byte
        run(32'h110, 8'd0, 4'h3, "R3 odd start", 0);
        // R2 R3 maximal span: 17 granules over 9 bytes
        run(32'h118, 8'd255, 4'h3, "R2 R3 17 granules", 0);
        // R3 odd start crossing into next byte
        run(32'h1F0, 8'd16, 4'h3, "R3 byte cross", 0);

        tmem[6'h0A] = 8'h35;   // granule 0x140 low nibble = 5
        tmem[6'h0C] = 8'h93;   // granule 0x190 high nibble = 9
        // R5 first granule fails -> access address
        run(32'h147, 8'd7, 4'h3, "R5 first granule", 0);
        // R4 R5 third granule fails, reads stop at its byte
        run(32'h128, 8'd40, 4'h3, "R4 R5 later granule", 0);
        // R1 high nibble belongs to upper granule
        run(32'h180, 8'd31, 4'h3, "R1 high nibble fail", 0);
        run(32'h190, 8'd0, 4'h9, "R1 high nibble match", 0);
        run(32'h180, 8'd0, 4'h3, "R1 low nibble match", 0);
        // R4 wrong pointer tag fails at once
        run(32'h203, 8'd100, 4'h7, "R4 tag mismatch", 0);
        // R7 start pulse while busy
        run(32'h118, 8'd200, 4'h3, "R7 ignored start", 1);
        repeat (4) @(negedge clk);
        chk(q.size() == 0 && !busy, "R7 idle after", 32'(busy), 32'd0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule